// File: doc/BRIEF.md
# UART Register Block with Prioritized Interrupt

This block is the bus-facing control and status layer of a small UART. A processor reaches eight 32-bit registers through a word-addressed bus port. Received bytes arrive from a serial shifter on a byte-valid input. The block holds one byte and tracks its line status. Writes to the data register leave on a byte-valid transmit output. The block also keeps the control words that the shifter and baud generator need, and presents them on output pins.

A single interrupt line is raised from four sources in fixed priority. The cause is encoded into a 3-bit identification register. That register and the interrupt line are recomputed every cycle from the state the block enters, so they always agree with the status registers. The error flags, the transmitter-empty flags and the modem status are supplied by the surrounding logic. The block latches or mirrors them and does no bit-level checking of its own.

Register word indices, in order: 0 data, 1 interrupt enable, 2 interrupt identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 divisor. The byte address is the index times four.

Top module: `uart_regblk`

## Requirements
- R1: A read decodes only aligned byte addresses 0..28. Index 2 returns the identification code, index 5 returns line status and index 6 returns modem status, each in the low bits. Indices 1, 3, 4 and 7 read as zero. An unaligned address, or any address at 32 or above, reads zero.
- R2: After reset, line status reads 0x60 (bit 5 transmit holding empty and bit 6 transmitter empty are set, with both inputs high). Identification reads 0x1, the held byte is zero, irq is low and rx_ready is high.
- R3: When rx_valid is high at a clock edge, rx_byte is stored and data ready (line status bit 0) is set. rx_ready is low while data ready is set.
- R4: If rx_valid arrives while data ready is set and the data register is not read in that cycle, overrun (line status bit 1) is set and the new byte replaces the held one.
- R5: Reading index 0 returns the held byte in bits 7:0 and clears data ready. If rx_valid arrives in the same cycle as the read, the new byte is stored, data ready stays set and no overrun is flagged.
- R6: With rx_valid, rx_err bit 0 sets parity error (status bit 2), bit 1 sets framing error (bit 3) and bit 2 sets break (bit 4). Bits 1 to 4 stay set until err_clr is high at an edge. A set in the same cycle as err_clr wins.
- R7: Line status bits 5 and 6 follow tx_hold_empty and tx_empty one clock later.
- R8: A write to index 0 drives tx_valid high for one cycle after the write, with tx_byte equal to write data bits 7:0.
- R9: Writes to indices 2, 5 and 6 are ignored. So are writes to unaligned or out-of-range addresses.
- R10: Writes to index 3, 4 and 7 appear on line_ctrl (data bits 7:0), modem_ctrl (bits 7:0) and divisor (bits DIVW-1:0) after the write edge. A write to index 1 sets the four enables from data bits 3:0: bit 0 receive, bit 1 transmit-empty, bit 2 line error, bit 3 modem.
- R11: The interrupt cause is chosen in priority order. Highest is any of status bits 1 to 4 with the line enable (code 3'b110). Next is data ready with the receive enable (3'b100). Next is transmit holding empty with the transmit enable (3'b010). Lowest is any modem status bit 3:0 with the modem enable (3'b000).
- R12: With no enabled source active, irq is low and the code is 3'b001. irq and the code take effect at the same edge as the status change that causes them.
- R13: Modem status mirrors modem_in one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 3 | Parity, framing, break flags with rx_valid |
| err_clr | input | 1 | Clears sticky error flags |
| rx_ready | output | 1 | High while no byte is held |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| tx_empty | input | 1 | Transmitter fully idle |
| modem_in | input | 8 | Modem status (low nibble are deltas) |
| line_ctrl | output | 8 | Line control word |
| modem_ctrl | output | 8 | Modem control word |
| divisor | output | DIVW | Baud divisor |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with ADDR_W = 6 and DIVW = 12. With ADDR_W = 6 the full byte address space of 64 addresses can be swept. That space includes every unaligned address and a whole out-of-range upper half, so the decode and the ignore rules are checked completely. A 12-bit divisor shows the width truncation on the control output. The four enable bits and the four interrupt sources together form only 256 combinations, and the bench applies every one. It compares the identification code and the irq line against a priority function it computes itself.

// File: rtl/uart_regblk_pkg.sv
package uart_regblk_pkg;

    localparam int NUM_REGS = 8;

    // register word indices
    localparam int RI_DATA  = 0;
    localparam int RI_IEN   = 1;
    localparam int RI_IID   = 2;
    localparam int RI_LCTL  = 3;
    localparam int RI_MCTL  = 4;
    localparam int RI_LSTAT = 5;
    localparam int RI_MSTAT = 6;
    localparam int RI_DIV   = 7;

    // enable bit positions
    localparam int EN_RX    = 0;
    localparam int EN_THR   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    // identification codes
    localparam logic [2:0] IID_LINE  = 3'b110;
    localparam logic [2:0] IID_RXD   = 3'b100;
    localparam logic [2:0] IID_THR   = 3'b010;
    localparam logic [2:0] IID_MODEM = 3'b000;
    localparam logic [2:0] IID_NONE  = 3'b001;

    typedef struct packed {
        logic [7:0] rbyte;
        logic       dr;
        logic       oe;
        logic       pe;
        logic       fe;
        logic       bi;
    } rx_state_t;

    typedef struct packed {
        logic       irq;
        logic [2:0] iid;
    } irq_state_t;

endpackage

// File: rtl/uart_regblk_decode.sv
module uart_regblk_decode
    import uart_regblk_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic [NUM_REGS-1:0] rd_sel
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int LO    = 2;
    localparam int HI    = IDX_W + LO;

    logic             aligned;
    logic             upper_ok;
    logic [IDX_W-1:0] idx;

    assign aligned = (bus_addr[LO-1:0] == '0);
    assign idx     = bus_addr[HI-1:LO];

    generate
        if (ADDR_W > HI) begin : g_upper
            assign upper_ok = ~|bus_addr[ADDR_W-1:HI];
        end else begin : g_no_upper
            assign upper_ok = 1'b1;
        end
    endgenerate

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
            logic hit;
            assign hit       = bus_valid && aligned && upper_ok && (idx == IDX_W'(g));
            assign wr_sel[g] = hit && bus_write;
            assign rd_sel[g] = hit && !bus_write;
        end
    endgenerate

endmodule

// File: rtl/uart_regblk_rxhold.sv
module uart_regblk_rxhold
    import uart_regblk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_valid,
    input  logic [7:0] rx_byte,
    input  logic [2:0] rx_err,
    input  logic      err_clr,
    input  logic      data_rd,
    output rx_state_t st_q,
    output rx_state_t st_d
);
    always_comb begin
        st_d = st_q;
        if (err_clr) begin
            st_d.oe = 1'b0;
            st_d.pe = 1'b0;
            st_d.fe = 1'b0;
            st_d.bi = 1'b0;
        end
        if (data_rd) begin
            st_d.dr = 1'b0;
        end
        if (rx_valid) begin
            if (st_q.dr && !data_rd) begin
                st_d.oe = 1'b1;
            end
            st_d.rbyte = rx_byte;
            st_d.dr    = 1'b1;
            if (rx_err[0]) st_d.pe = 1'b1;
            if (rx_err[1]) st_d.fe = 1'b1;
            if (rx_err[2]) st_d.bi = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (st_q.dr && st_q.rbyte == $past(rx_byte)));

    p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && st_q.dr && !data_rd) |=> st_q.oe);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_valid) |=> !st_q.dr);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pe && !err_clr) |=> st_q.pe);

endmodule

// File: rtl/uart_regblk_irq.sv
module uart_regblk_irq
    import uart_regblk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] ien,
    input  logic       line_err,
    input  logic       dr,
    input  logic       thre,
    input  logic [3:0] modem_delta,
    output logic       irq,
    output logic [2:0] iid
);
    irq_state_t st_d;
    irq_state_t st_q;
    logic       modem_any;

    assign modem_any = |modem_delta;

    always_comb begin
        st_d.irq = 1'b1;
        if (line_err && ien[EN_LINE]) begin
            st_d.iid = IID_LINE;
        end else if (dr && ien[EN_RX]) begin
            st_d.iid = IID_RXD;
        end else if (thre && ien[EN_THR]) begin
            st_d.iid = IID_THR;
        end else if (modem_any && ien[EN_MODEM]) begin
            st_d.iid = IID_MODEM;
        end else begin
            st_d.irq = 1'b0;
            st_d.iid = IID_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.irq <= 1'b0;
            st_q.iid <= IID_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
    assign iid = st_q.iid;

    p_line_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[EN_LINE] && line_err) |=> (irq && iid == IID_LINE));

    p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((ien & {modem_any, line_err, thre, dr}) == 4'b0) |=> (!irq && iid == IID_NONE));

endmodule

// File: rtl/uart_regblk.sv
module uart_regblk
    import uart_regblk_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DIVW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic [2:0]        rx_err,
    input  logic              err_clr,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_hold_empty,
    input  logic              tx_empty,
    input  logic [7:0]        modem_in,
    output logic [7:0]        line_ctrl,
    output logic [7:0]        modem_ctrl,
    output logic [DIVW-1:0]   divisor,
    output logic              irq
);
    typedef struct packed {
        logic [3:0]      ien;
        logic [7:0]      lctl;
        logic [7:0]      mctl;
        logic [DIVW-1:0] div;
        logic            thre;
        logic            temt;
        logic [7:0]      msr;
        logic            txv;
        logic [7:0]      txb;
    } ctl_t;

    logic [NUM_REGS-1:0] wr_sel;
    logic [NUM_REGS-1:0] rd_sel;
    rx_state_t           rx_q;
    rx_state_t           rx_d;
    ctl_t                ctl_q;
    ctl_t                ctl_d;
    logic [2:0]          iid;
    logic [7:0]          lsr;

    uart_regblk_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .wr_sel    (wr_sel),
        .rd_sel    (rd_sel)
    );

    uart_regblk_rxhold u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_err   (rx_err),
        .err_clr  (err_clr),
        .data_rd  (rd_sel[RI_DATA]),
        .st_q     (rx_q),
        .st_d     (rx_d)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.txv  = 1'b0;
        ctl_d.thre = tx_hold_empty;
        ctl_d.temt = tx_empty;
        ctl_d.msr  = modem_in;
        if (wr_sel[RI_DATA]) begin
            ctl_d.txv = 1'b1;
            ctl_d.txb = bus_wdata[7:0];
        end
        if (wr_sel[RI_IEN])  ctl_d.ien  = bus_wdata[3:0];
        if (wr_sel[RI_LCTL]) ctl_d.lctl = bus_wdata[7:0];
        if (wr_sel[RI_MCTL]) ctl_d.mctl = bus_wdata[7:0];
        if (wr_sel[RI_DIV])  ctl_d.div  = bus_wdata[DIVW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.thre <= 1'b1;
            ctl_q.temt <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    uart_regblk_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ien         (ctl_d.ien),
        .line_err    (rx_d.oe | rx_d.pe | rx_d.fe | rx_d.bi),
        .dr          (rx_d.dr),
        .thre        (ctl_d.thre),
        .modem_delta (ctl_d.msr[3:0]),
        .irq         (irq),
        .iid         (iid)
    );

    assign lsr = {1'b0, ctl_q.temt, ctl_q.thre, rx_q.bi, rx_q.fe, rx_q.pe, rx_q.oe, rx_q.dr};

    always_comb begin
        bus_rdata = '0;
        if (rd_sel[RI_DATA])  bus_rdata[7:0] = rx_q.rbyte;
        if (rd_sel[RI_IID])   bus_rdata[2:0] = iid;
        if (rd_sel[RI_LSTAT]) bus_rdata[7:0] = lsr;
        if (rd_sel[RI_MSTAT]) bus_rdata[7:0] = ctl_q.msr;
    end

    assign rx_ready   = !rx_q.dr;
    assign tx_valid   = ctl_q.txv;
    assign tx_byte    = ctl_q.txb;
    assign line_ctrl  = ctl_q.lctl;
    assign modem_ctrl = ctl_q.mctl;
    assign divisor    = ctl_q.div;

    p_tx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == '0) |=> (tx_valid && tx_byte == $past(bus_wdata[7:0])));

    p_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_ready);

    p_irq_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !iid[0]);

    p_mirror_r13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctl_q.msr == $past(modem_in)));

endmodule

// File: tb/sim_uart_regblk.sv
`timescale 1ns/1ps
module sim_uart_regblk;
    localparam int AW = 6;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_valid, bus_write;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          rx_valid;
    logic [7:0]    rx_byte;
    logic [2:0]    rx_err;
    logic          err_clr, rx_ready, tx_valid;
    logic [7:0]    tx_byte;
    logic          tx_hold_empty, tx_empty;
    logic [7:0]    modem_in, line_ctrl, modem_ctrl;
    logic [DW-1:0] divisor;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    uart_regblk #(.ADDR_W(AW), .DIVW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_err(rx_err), .err_clr(err_clr),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_hold_empty(tx_hold_empty), .tx_empty(tx_empty), .modem_in(modem_in),
        .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl), .divisor(divisor), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        tick();
        bus_valid = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic [2:0] e);
        rx_valid = 1'b1; rx_byte = b; rx_err = e;
        tick();
        rx_valid = 1'b0; rx_err = 3'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    function automatic logic [2:0] exp_code(input logic [3:0] en, input logic [3:0] src);
        if (src[0] && en[2]) return 3'b110;
        if (src[1] && en[0]) return 3'b100;
        if (src[2] && en[1]) return 3'b010;
        if (src[3] && en[3]) return 3'b000;
        return 3'b001;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] ex;
        rst_n = 1'b0; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
        rx_valid = 0; rx_byte = '0; rx_err = '0; err_clr = 0;
        tx_hold_empty = 1; tx_empty = 1; modem_in = 8'hA0;
        tick();
        do_reset();

        // R2 / R1: reset state and full address sweep
        chk("R2 irq", {31'b0, irq}, 32'd0);
        chk("R2 rx_ready", {31'b0, rx_ready}, 32'd1);
        for (int a = 0; a < 64; a++) begin
            bus_rd(AW'(a), rd);
            ex = 32'd0;
            if (a[1:0] == 2'b00 && a < 32) begin
                case (a / 4)
                    2: ex = 32'h1;
                    5: ex = 32'h60;
                    6: ex = 32'hA0;
                    default: ex = 32'h0;
                endcase
            end
            chk((a == 8 || a == 20) ? "R2 reset read" : "R1 decode read", rd, ex);
        end

        // R10: control words, R1 write-only read zero
        bus_wr(6'd12, 32'hFFFF_FFA5);
        bus_wr(6'd16, 32'h0000_013C);
        bus_wr(6'd28, 32'h1234_5ABC);
        chk("R10 line_ctrl", {24'b0, line_ctrl}, 32'hA5);
        chk("R10 modem_ctrl", {24'b0, modem_ctrl}, 32'h3C);
        chk("R10 divisor", {20'b0, divisor}, 32'hABC);
        bus_rd(6'd12, rd); chk("R1 lctl reads zero", rd, 0);
        bus_rd(6'd28, rd); chk("R1 div reads zero", rd, 0);

        // R9: read-only and invalid writes ignored
        bus_wr(6'd20, 32'hFFFF_FFFF);
        bus_wr(6'd8,  32'hFFFF_FFFF);
        bus_wr(6'd24, 32'hFFFF_FFFF);
        bus_rd(6'd20, rd); chk("R9 lstat unchanged", rd, 32'h60);
        bus_rd(6'd8,  rd); chk("R9 iid unchanged", rd, 32'h1);
        bus_rd(6'd24, rd); chk("R9 mstat unchanged", rd, 32'hA0);
        bus_wr(6'd13, 32'h11);
        bus_wr(6'd44, 32'h22);
        chk("R9 invalid write ignored", {24'b0, line_ctrl}, 32'hA5);
        chk("R9 no tx from invalid", {31'b0, tx_valid}, 0);

        // R8: transmit
        bus_wr(6'd0, 32'h1234_5678);
        chk("R8 tx_valid", {31'b0, tx_valid}, 1);
        chk("R8 tx_byte", {24'b0, tx_byte}, 32'h78);
        tick();
        chk("R8 tx one cycle", {31'b0, tx_valid}, 0);

        // R3 / R5: receive and read
        send_rx(8'h5A, 3'b0);
        chk("R3 rx_ready low", {31'b0, rx_ready}, 0);
        bus_rd(6'd20, rd); chk("R3 dr set", rd, 32'h61);
        bus_rd(6'd0, rd);  chk("R5 byte", rd, 32'h5A);
        bus_rd(6'd20, rd); chk("R5 dr cleared", rd, 32'h60);
        chk("R3 rx_ready high", {31'b0, rx_ready}, 1);

        // R4: overrun
        send_rx(8'h11, 3'b0);
        send_rx(8'h22, 3'b0);
        bus_rd(6'd20, rd); chk("R4 overrun", rd, 32'h63);
        bus_rd(6'd0, rd);  chk("R4 overwritten", rd, 32'h22);
        bus_rd(6'd20, rd); chk("R6 oe sticky", rd, 32'h62);
        err_clr = 1; tick(); err_clr = 0;
        bus_rd(6'd20, rd); chk("R6 clear", rd, 32'h60);

        // R5: read and receive in the same cycle
        send_rx(8'h33, 3'b0);
        bus_valid = 1; bus_write = 0; bus_addr = 6'd0;
        rx_valid = 1; rx_byte = 8'h44;
        #1 rd = bus_rdata;
        tick();
        bus_valid = 0; rx_valid = 0;
        chk("R5 concurrent old byte", rd, 32'h33);
        bus_rd(6'd20, rd); chk("R5 concurrent no overrun", rd, 32'h61);
        bus_rd(6'd0, rd);  chk("R5 concurrent new byte", rd, 32'h44);

        // R6: error flags
        send_rx(8'h01, 3'b001);
        bus_rd(6'd20, rd); chk("R6 parity", rd, 32'h65);
        bus_rd(6'd0, rd);
        bus_rd(6'd20, rd); chk("R6 parity sticky", rd, 32'h64);
        send_rx(8'h02, 3'b010);
        bus_rd(6'd20, rd); chk("R6 framing", rd, 32'h6D);
        bus_rd(6'd0, rd);
        send_rx(8'h03, 3'b100);
        bus_rd(6'd20, rd); chk("R6 break", rd, 32'h7D);
        err_clr = 1; tick(); err_clr = 0;
        bus_rd(6'd20, rd); chk("R6 clear keeps dr", rd, 32'h61);
        err_clr = 1; rx_valid = 1; rx_byte = 8'h04; rx_err = 3'b001;
        tick();
        err_clr = 0; rx_valid = 0; rx_err = 0;
        bus_rd(6'd20, rd); chk("R6 set wins", rd, 32'h67);
        err_clr = 1; tick(); err_clr = 0;
        bus_rd(6'd0, rd);
        bus_rd(6'd20, rd); chk("R6 all clear", rd, 32'h60);

        // R7: transmitter flags
        tx_hold_empty = 0; tick();
        bus_rd(6'd20, rd); chk("R7 thre", rd, 32'h40);
        tx_empty = 0; tick();
        bus_rd(6'd20, rd); chk("R7 temt", rd, 32'h00);
        tx_hold_empty = 1; tx_empty = 1; tick();

        // R13: modem mirror
        modem_in = 8'h5C; tick();
        bus_rd(6'd24, rd); chk("R13 mirror", rd, 32'h5C);

        // R11 / R12: exhaustive priority sweep
        for (int en = 0; en < 16; en++) begin
            for (int src = 0; src < 16; src++) begin
                tx_hold_empty = src[2];
                modem_in = src[3] ? 8'h21 : 8'h20;
                do_reset();
                if (src[0]) begin
                    send_rx(8'hEE, 3'b001);
                    bus_rd(6'd0, rd);
                end
                if (src[1]) send_rx(8'h77, 3'b0);
                bus_wr(6'd4, 32'(en));
                ex = {29'b0, exp_code(4'(en), 4'(src))};
                chk("R11 irq line", {31'b0, irq}, (ex == 32'h1) ? 32'd0 : 32'd1);
                bus_rd(6'd8, rd);
                chk("R11 R12 code", rd, ex);
            end
        end

        // R12: irq follows status at the same edge
        tx_hold_empty = 1; modem_in = 8'h00;
        do_reset();
        bus_wr(6'd4, 32'h1);
        send_rx(8'h99, 3'b0);
        chk("R12 irq on receive", {31'b0, irq}, 1);
        bus_rd(6'd0, rd);
        chk("R12 irq drops on read", {31'b0, irq}, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule